// File: doc/BRIEF.md
# Packed Byte Vector Load Unit

This block carries out one kind of vector load. Each request brings a scalar base address, a small signed offset counted in 16-byte lines, the index of the destination vector register and an element selector. The block forms the effective address and aligns it down to a 16-byte line. It then reads that 128-bit line through a synchronous memory read port and keeps every second byte of it. Each kept byte goes into one 16-bit lane of an eight-lane vector register write.

Every kept byte sits inside its lane so that its top bit lands on lane bit 14. Lane bit 15 and the seven low lane bits are zero. This layout suits unpacking interleaved 8-bit samples, such as chroma pairs, into fixed-point lanes with one guard bit.

The element selector must be zero for this load. A nonzero value raises an error flag that travels with the write. It changes nothing else.

The unit is fully pipelined and accepts one request every clock. A request presented in cycle c is written back in cycle c+3.

Top module: `packed_byte_vload`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `vr_we`, `elem_err` and `mem_rd_en` are low. A request that is still in the pipeline when `rst` is raised never produces a write.
- R2: A request presented in cycle c drives `mem_rd_en` high in cycle c+1 only. In that cycle `mem_rd_addr` equals `req_base` plus the sign-extended `req_offset` times 16, modulo 2^ADDR_W, with the low four bits cleared.
- R3: In the write, lane i (bits 16i+15 down to 16i of `vr_data`, i = 0..7) holds byte 2i of the line read. Byte j of the line is `mem_rd_data[127-8j -: 8]`, so byte 0 is the most significant byte. The byte sits in lane bits 14:7.
- R4: In every write, lane bit 15 and lane bits 6:0 of all eight lanes are zero.
- R5: `vr_we` is high for exactly one cycle per request, in cycle c+3 for a request in cycle c. In that cycle `vr_idx` equals that request's `req_vt`. `vr_we` never rises without a request.
- R6: When the request's `req_elem` is nonzero, `elem_err` is high in the same cycle as its `vr_we`, and is low otherwise. `vr_data` and `vr_idx` are the same as for a zero element field.
- R7: Requests presented in consecutive cycles each produce their own write, in consecutive cycles and in issue order.
- R8: The low four bits of `mem_rd_addr` are zero whenever `mem_rd_en` is high, whatever the low bits of `req_base` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present this cycle |
| req_base | input | ADDR_W (32) | Scalar base address |
| req_offset | input | OFF_W (7) | Signed offset in 16-byte lines |
| req_vt | input | VR_AW (5) | Destination vector register index |
| req_elem | input | ELEM_W (4) | Element selector, expected zero |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W (32) | Line-aligned byte address of the read |
| mem_rd_data | input | 128 | Line returned one cycle after the strobe |
| vr_we | output | 1 | Vector register write enable |
| vr_idx | output | VR_AW (5) | Vector register being written |
| vr_data | output | LANES*LANE_W (128) | Eight formatted lanes |
| elem_err | output | 1 | Nonzero element selector seen for this write |

## Verification
The checker assumes two things about the environment. The memory returns the line on `mem_rd_data` exactly one clock after `mem_rd_en`. `req_valid` stays low while `rst` is high, so the shadow pipeline that the latency and index checks follow starts out empty. The bench keeps to both rules: it models the memory as a registered read of a fixed array, and it raises `req_valid` only between resets, including the test that asserts reset behind a request that is still in flight. Random stimulus covers all offsets (negative ones included), any base alignment and nonzero element fields. Directed cases cover address wrap-around and back-to-back issue.

// File: rtl/vlu_pkg.sv
package vlu_pkg;
  localparam int BYTE_W = 8;

  // bits a byte must move up so its top bit reaches msb_pos
  function automatic int lane_shift(input int msb_pos);
    return msb_pos - BYTE_W + 1;
  endfunction

  // one line holds two bytes per lane (every second one is kept)
  function automatic int line_bits(input int lanes);
    return lanes * 2 * BYTE_W;
  endfunction

  function automatic int line_lsbs(input int lanes);
    return $clog2(lanes * 2);
  endfunction
endpackage

// File: rtl/vlu_agen.sv
module vlu_agen import vlu_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  parameter int LANES  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] line_addr
);
  localparam int LSB = line_lsbs(LANES);
  localparam int EXT = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] ALIGN = ~((ADDR_W'(1) << LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] off_scaled;
  logic [ADDR_W-1:0] ea;

  assign off_scaled = {{EXT{offset[OFF_W-1]}}, offset} << LSB;
  assign ea         = base + off_scaled;
  assign line_addr  = ea & ALIGN;
endmodule

// File: rtl/vlu_pipe_reg.sv
module vlu_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_pay,
  output logic         out_v,
  output logic [W-1:0] out_pay
);
  always_ff @(posedge clk) begin
    if (rst) out_v <= 1'b0;
    else     out_v <= in_v;
  end

  // payload carries no reset; it loads only with a valid request
  always_ff @(posedge clk) begin
    if (in_v) out_pay <= in_pay;
  end
endmodule

// File: rtl/vlu_lane_fmt.sv
module vlu_lane_fmt import vlu_pkg::*; #(
  parameter int LANES   = 8,
  parameter int LANE_W  = 16,
  parameter int MSB_POS = 14
) (
  input  logic [line_bits(LANES)-1:0] line,
  output logic [LANES*LANE_W-1:0]     lanes
);
  localparam int LB = line_bits(LANES);
  localparam int SH = lane_shift(MSB_POS);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int SRC_HI = LB - 1 - 2 * i * BYTE_W;
    assign lanes[i*LANE_W +: LANE_W] = LANE_W'(line[SRC_HI -: BYTE_W]) << SH;
  end
endmodule

// File: rtl/packed_byte_vload.sv
module packed_byte_vload import vlu_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 7,
  parameter int VR_AW   = 5,
  parameter int ELEM_W  = 4,
  parameter int LANES   = 8,
  parameter int LANE_W  = 16,
  parameter int MSB_POS = 14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_base,
  input  logic [OFF_W-1:0]          req_offset,
  input  logic [VR_AW-1:0]          req_vt,
  input  logic [ELEM_W-1:0]         req_elem,
  output logic                      mem_rd_en,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic [line_bits(LANES)-1:0] mem_rd_data,
  output logic                      vr_we,
  output logic [VR_AW-1:0]          vr_idx,
  output logic [LANES*LANE_W-1:0]   vr_data,
  output logic                      elem_err
);
  localparam int SIDE_W = VR_AW + 1;
  localparam int S1_W   = ADDR_W + SIDE_W;

  // stage 0: address generation
  logic [ADDR_W-1:0] line_addr;

  vlu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
    .base     (req_base),
    .offset   (req_offset),
    .line_addr(line_addr)
  );

  // stage 1: registered read request
  logic            s1_v;
  logic [S1_W-1:0] s1_pay;

  vlu_pipe_reg #(.W(S1_W)) u_s1 (
    .clk    (clk),
    .rst    (rst),
    .in_v   (req_valid),
    .in_pay ({line_addr, req_vt, |req_elem}),
    .out_v  (s1_v),
    .out_pay(s1_pay)
  );

  assign mem_rd_en   = s1_v;
  assign mem_rd_addr = s1_pay[SIDE_W +: ADDR_W];

  // stage 2: line returns from memory
  logic              s2_v;
  logic [SIDE_W-1:0] s2_pay;

  vlu_pipe_reg #(.W(SIDE_W)) u_s2 (
    .clk    (clk),
    .rst    (rst),
    .in_v   (s1_v),
    .in_pay (s1_pay[SIDE_W-1:0]),
    .out_v  (s2_v),
    .out_pay(s2_pay)
  );

  logic [LANES*LANE_W-1:0] fmt_vec;

  vlu_lane_fmt #(.LANES(LANES), .LANE_W(LANE_W), .MSB_POS(MSB_POS)) u_fmt (
    .line (mem_rd_data),
    .lanes(fmt_vec)
  );

  // stage 3: registered write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      vr_we    <= 1'b0;
      elem_err <= 1'b0;
    end else begin
      vr_we    <= s2_v;
      elem_err <= s2_v & s2_pay[0];
    end
  end

  always_ff @(posedge clk) begin
    if (s2_v) begin
      vr_idx  <= s2_pay[SIDE_W-1:1];
      vr_data <= fmt_vec;
    end
  end
endmodule

// File: rtl/vlu_chk.sv
module vlu_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 7,
  parameter int VR_AW   = 5,
  parameter int ELEM_W  = 4,
  parameter int LANES   = 8,
  parameter int LANE_W  = 16,
  parameter int MSB_POS = 14
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic [ADDR_W-1:0]       req_base,
  input logic [OFF_W-1:0]        req_offset,
  input logic [VR_AW-1:0]        req_vt,
  input logic [ELEM_W-1:0]       req_elem,
  input logic                    mem_rd_en,
  input logic [ADDR_W-1:0]       mem_rd_addr,
  input logic                    vr_we,
  input logic [VR_AW-1:0]        vr_idx,
  input logic [LANES*LANE_W-1:0] vr_data,
  input logic                    elem_err
);
  localparam int SH = MSB_POS - 7;

  function automatic logic [LANES*LANE_W-1:0] zero_mask();
    logic [LANES*LANE_W-1:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++)
      for (int b = 0; b < LANE_W; b++)
        if (b < SH || b > SH + 7) m[l*LANE_W+b] = 1'b1;
    return m;
  endfunction

  localparam logic [LANES*LANE_W-1:0] ZMASK = zero_mask();

  logic [ADDR_W-1:0] sum_addr;
  assign sum_addr = req_base + ADDR_W'($signed(req_offset)) * ADDR_W'(16);

  logic [2:0]       sh_v, sh_e;
  logic [VR_AW-1:0] sh_vt0, sh_vt1, sh_vt2;
  logic [ADDR_W-1:0] sh_a;
  logic             rst_q;

  always_ff @(posedge clk) begin
    rst_q  <= rst;
    sh_vt0 <= req_vt;
    sh_vt1 <= sh_vt0;
    sh_vt2 <= sh_vt1;
    sh_a   <= {sum_addr[ADDR_W-1:4], 4'b0000};
    if (rst) begin
      sh_v <= '0;
      sh_e <= '0;
    end else begin
      sh_v <= {sh_v[1:0], req_valid};
      sh_e <= {sh_e[1:0], |req_elem};
    end

    if (rst_q) begin
      assert_reset_quiet_R1: assert (!vr_we && !elem_err && !mem_rd_en)
        else $error("outputs active right after reset");
    end
    if (!rst) begin
      assert_rd_strobe_R2: assert (mem_rd_en == sh_v[0])
        else $error("read strobe not one cycle after request");
      if (sh_v[0]) begin
        assert_rd_addr_R2: assert (mem_rd_addr == sh_a)
          else $error("read address mismatch");
      end
      assert_we_latency_R5: assert (vr_we == sh_v[2])
        else $error("write enable latency wrong");
      if (vr_we) begin
        assert_we_index_R5: assert (vr_idx == sh_vt2)
          else $error("write index mismatch");
      end
      assert_elem_flag_R6: assert (elem_err == (sh_v[2] && sh_e[2]))
        else $error("element flag mismatch");
    end
  end

  assert_lane_zero_R4: assert property (@(posedge clk) disable iff (rst)
    vr_we |-> ((vr_data & ZMASK) == '0))
    else $error("guard or low lane bits set");

  assert_rd_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[3:0] == 4'b0000))
    else $error("read address not line aligned");
endmodule

bind packed_byte_vload vlu_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .VR_AW(VR_AW), .ELEM_W(ELEM_W),
  .LANES(LANES), .LANE_W(LANE_W), .MSB_POS(MSB_POS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_base   (req_base),
  .req_offset (req_offset),
  .req_vt     (req_vt),
  .req_elem   (req_elem),
  .mem_rd_en  (mem_rd_en),
  .mem_rd_addr(mem_rd_addr),
  .vr_we      (vr_we),
  .vr_idx     (vr_idx),
  .vr_data    (vr_data),
  .elem_err   (elem_err)
);

// File: tb/tb_packed_byte_vload.sv
`timescale 1ns/1ps
module tb_packed_byte_vload;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [31:0]  req_base = '0;
  logic [6:0]   req_offset = '0;
  logic [4:0]   req_vt = '0;
  logic [3:0]   req_elem = '0;
  logic         mem_rd_en;
  logic [31:0]  mem_rd_addr;
  logic [127:0] mem_rd_data;
  logic         vr_we;
  logic [4:0]   vr_idx;
  logic [127:0] vr_data;
  logic         elem_err;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  packed_byte_vload dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
    .req_offset(req_offset), .req_vt(req_vt), .req_elem(req_elem),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .vr_we(vr_we), .vr_idx(vr_idx), .vr_data(vr_data), .elem_err(elem_err)
  );

  // memory model: 256 lines, registered read
  logic [127:0] mem [256];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:4]];

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [6:0] o);
    logic [31:0] s;
    s = b + {{25{o[6]}}, o} * 32'd16;
    return {s[31:4], 4'h0};
  endfunction

  function automatic logic [127:0] exp_vec(input logic [31:0] a);
    logic [127:0] ln, r;
    ln = mem[a[11:4]];
    for (int i = 0; i < 8; i++) r[16*i +: 16] = {1'b0, ln[127-16*i -: 8], 7'b0};
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bench shadow pipeline of expected results
  logic [3:0]  p_v;
  logic [3:0]  p_e;
  logic [4:0]  p_vt [3];
  logic [31:0] p_a  [3];
  always @(posedge clk) begin
    if (rst) begin
      p_v <= '0; p_e <= '0;
    end else begin
      p_v <= {p_v[2:0], req_valid};
      p_e <= {p_e[2:0], |req_elem};
    end
    p_vt[0] <= req_vt;  p_vt[1] <= p_vt[0]; p_vt[2] <= p_vt[1];
    p_a[0]  <= exp_addr(req_base, req_offset); p_a[1] <= p_a[0]; p_a[2] <= p_a[1];
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(mem_rd_en == p_v[0], "R2 strobe", 128'(mem_rd_en), 128'(p_v[0]));
      if (p_v[0]) begin
        check(mem_rd_addr == p_a[0], "R2 address", 128'(mem_rd_addr), 128'(p_a[0]));
        check(mem_rd_addr[3:0] == 4'h0, "R8 alignment", 128'(mem_rd_addr[3:0]), 128'(0));
      end
      if (p_v[2]) begin
        check(vr_we === 1'b1, p_v[3] ? "R7 back-to-back write" : "R5 write enable", 128'(vr_we), 128'(1));
        check(vr_idx == p_vt[2], "R5 index", 128'(vr_idx), 128'(p_vt[2]));
        check(vr_data == exp_vec(p_a[2]), "R3 lanes", vr_data, exp_vec(p_a[2]));
        check((vr_data & {8{16'h807F}}) == '0, "R4 zero bits", vr_data & {8{16'h807F}}, 128'(0));
        check(elem_err == p_e[2], "R6 element flag", 128'(elem_err), 128'(p_e[2]));
      end else begin
        check(vr_we == 1'b0, "R5 no spurious write", 128'(vr_we), 128'(0));
        check(elem_err == 1'b0, "R6 flag idle", 128'(elem_err), 128'(0));
      end
    end
  end

  task automatic issue(input logic [31:0] b, input logic [6:0] o, input logic [4:0] vt, input logic [3:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_offset = o; req_vt = vt; req_elem = e;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom, $urandom, $urandom};

    repeat (3) @(negedge clk);
    check(!vr_we && !elem_err && !mem_rd_en, "R1 in reset", 128'({vr_we, elem_err, mem_rd_en}), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check(!vr_we && !elem_err && !mem_rd_en, "R1 after reset", 128'({vr_we, elem_err, mem_rd_en}), 128'(0));

    // directed corners
    issue(32'h0000_0000, 7'h00, 5'd1, 4'h0);
    issue(32'h0000_0FF7, 7'h01, 5'd2, 4'h0);   // wraps line index, unaligned base (R8)
    issue(32'h0000_0010, 7'h40, 5'd3, 4'h0);   // most negative offset
    issue(32'h0000_003C, 7'h3F, 5'd4, 4'h0);   // most positive offset
    issue(32'h0000_0120, 7'h00, 5'd31, 4'hF);  // nonzero element (R6)
    issue(32'hFFFF_FFFF, 7'h7F, 5'd0, 4'h1);
    idle(5);

    // reset while a request is in flight (R1)
    issue(32'h0000_0200, 7'h02, 5'd9, 4'h0);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(vr_we == 1'b0, "R1 flushed request", 128'(vr_we), 128'(0));
      @(negedge clk);
    end

    // random mix, about three requests in four cycles
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(3) != 0)
        issue($urandom, 7'($urandom), 5'($urandom), ($urandom_range(3) == 0) ? 4'($urandom) : 4'h0);
      else
        idle(1);
    end
    idle(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule